// File: doc/BRIEF.md
# SPI Register-Access Slave Port

This block is the slave side of a serial port that lets an external bus master read and write a bank of 8-bit registers over SPI with clock polarity and phase both set (mode 3). The serial clock idles high; the master moves its data on falling edges and the port samples on rising edges. The port shifts data out on falling edges as well. Each transaction opens with chip select falling. The first byte is a command byte, sent MSB first: bit 7 is the direction (1 = read, 0 = write), bit 6 is the multi-byte flag and bits 5:0 are the register address. Every later byte is a data byte. With the flag set, the register pointer steps forward by one after each data byte and wraps from 0x3F to 0x00. With the flag clear, every data byte goes to the same register.

The register bank itself sits outside the block, behind a simple synchronous port. The block issues a one-cycle write strobe with an address and data, or a one-cycle read strobe with an address. Read data must be valid in the same cycle as the read strobe. The port also watches writes to register 0x31. Bit 6 of that register sets the wire mode. When it is 0 the port runs 4-wire, with a separate data output that is enabled for the whole transaction. When it is 1 the port runs 3-wire: the data line is shared, and the port enables its output only during the data phase of a read.

All SPI inputs pass through synchronisers into the system clock domain, and the serial clock edges are detected there. The system clock must run at least four times as fast as the serial clock.

Top module: `spi_regport`

## Requirements
- R1: After reset, `spi_dout_en`, `reg_we` and `reg_re` are low and the port is in 4-wire mode.
- R2: In a write transaction (command bit 7 = 0), each completed data byte, sampled MSB first on rising serial clock edges, produces exactly one single-cycle `reg_we` pulse. The pulse carries the current pointer on `reg_addr` and the byte on `reg_wdata`.
- R3: In a read transaction (command bit 7 = 1), the port pulses `reg_re` once with the addressed register on `reg_addr`. It then shifts that register's value out MSB first on `spi_dout`, with each bit changing on a falling serial clock edge so that it is valid at the next rising edge.
- R4: With command bit 6 set, the pointer advances by one after each data byte, for both reads and writes.
- R5: With command bit 6 clear, every data byte in the transaction accesses the address given in the command byte.
- R6: Auto-increment wraps the pointer from 0x3F to 0x00.
- R7: Raising chip select drops any partial byte. A partly received data byte causes no write, and the next transaction starts again with a command byte.
- R8: In 4-wire mode, `spi_dout_en` is high throughout a transaction while chip select is low.
- R9: Writing a byte with bit 6 = 1 to register 0x31 selects 3-wire mode, and writing bit 6 = 0 returns the port to 4-wire mode. The other bits of that byte have no effect on the mode. In 3-wire mode, `spi_dout_en` is low during writes and during the command byte, and high during the data phase of a read.
- R10: Once chip select has been high for four system clock cycles, `spi_dout_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idles high |
| spi_din | input | 1 | Serial data in (the shared line's input in 3-wire mode) |
| spi_dout | output | 1 | Serial data out |
| spi_dout_en | output | 1 | Output enable for the data-out driver |
| reg_addr | output | 6 | Register address of the current access |
| reg_wdata | output | 8 | Write data |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_re | output | 1 | Single-cycle read strobe |
| reg_rdata | input | 8 | Read data, valid in the cycle `reg_re` is high |

## Verification
The bench builds the port with its defaults: two synchroniser stages, and the mode bit at position 6 of register 0x31. Because the pointer is 6 bits wide, a two-byte burst starting at 0x3F reaches the wrap to 0x00. The serial clock runs twelve times slower than the system clock, so the load of read data from the bank before the first outgoing falling edge is exercised with realistic margin. Writes to 0x31 with bit 6 set and clear, plus one with every other bit set, move the port between the two wire modes and check the bit position.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

    localparam int unsigned RP_ADDR_W = 6;
    localparam int unsigned RP_DATA_W = RP_ADDR_W + 2;
    localparam int unsigned RP_CNT_W  = $clog2(RP_DATA_W);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CMD  = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e                 phase;
        logic [RP_CNT_W-1:0]    bitcnt;
        logic [RP_DATA_W-1:0]   rx;
        logic [RP_DATA_W-1:0]   tx;
        logic                   rw;
        logic                   mb;
        logic [RP_ADDR_W-1:0]   ptr;
        logic [RP_ADDR_W-1:0]   acc;
        logic [RP_DATA_W-1:0]   wdata;
        logic                   we;
        logic                   re;
        logic                   dout;
        logic                   dout_en;
        logic                   wire3;
    } port_state_t;

endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
    parameter int unsigned WIDTH   = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= RST_VAL;
                    else        stage_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/spi_regport_edge.sv
module spi_regport_edge #(
    parameter logic IDLE_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o,
    output logic fall_o
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = level_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= IDLE_VAL;
        else        prev_q <= prev_d;
    end

    assign rise_o = level_i & ~prev_q;
    assign fall_o = ~level_i & prev_q;

endmodule

// File: rtl/spi_regport_core.sv
module spi_regport_core
    import spi_regport_pkg::*;
#(
    parameter logic [RP_ADDR_W-1:0] MODE_ADDR = 6'h31,
    parameter int unsigned          MODE_BIT  = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_act,
    input  logic                 sclk_rise,
    input  logic                 sclk_fall,
    input  logic                 din,
    input  logic [RP_DATA_W-1:0] reg_rdata,
    output logic [RP_ADDR_W-1:0] reg_addr,
    output logic [RP_DATA_W-1:0] reg_wdata,
    output logic                 reg_we,
    output logic                 reg_re,
    output logic                 dout,
    output logic                 dout_en,
    output logic                 wire3
);

    localparam logic [RP_CNT_W-1:0] LAST_BIT = RP_CNT_W'(RP_DATA_W - 1);

    port_state_t st_d, st_q;

    always_comb begin
        logic [RP_DATA_W-1:0] rx_next;
        logic [RP_ADDR_W-1:0] ptr_next;

        st_d    = st_q;
        st_d.we = 1'b0;
        st_d.re = 1'b0;

        rx_next  = {st_q.rx[RP_DATA_W-2:0], din};
        ptr_next = st_q.mb ? st_q.ptr + 1'b1 : st_q.ptr;

        if (!cs_act) begin
            // transaction closed: drop every partial count
            st_d.phase   = PH_IDLE;
            st_d.bitcnt  = '0;
            st_d.dout_en = 1'b0;
        end else if (st_q.phase == PH_IDLE) begin
            st_d.phase  = PH_CMD;
            st_d.bitcnt = '0;
            st_d.rx     = '0;
        end else begin
            // read data arrives in the strobe cycle; capture it
            if (st_q.re) begin
                st_d.tx = reg_rdata;
            end

            if (sclk_rise) begin
                st_d.rx     = rx_next;
                st_d.bitcnt = st_q.bitcnt + 1'b1;
                if (st_q.bitcnt == LAST_BIT) begin
                    if (st_q.phase == PH_CMD) begin
                        st_d.rw    = rx_next[RP_DATA_W-1];
                        st_d.mb    = rx_next[RP_DATA_W-2];
                        st_d.ptr   = rx_next[RP_ADDR_W-1:0];
                        st_d.phase = PH_DATA;
                        if (rx_next[RP_DATA_W-1]) begin
                            st_d.re  = 1'b1;
                            st_d.acc = rx_next[RP_ADDR_W-1:0];
                        end
                    end else begin
                        if (st_q.rw) begin
                            st_d.re  = 1'b1;
                            st_d.acc = ptr_next;
                        end else begin
                            st_d.we    = 1'b1;
                            st_d.acc   = st_q.ptr;
                            st_d.wdata = rx_next;
                            if (st_q.ptr == MODE_ADDR) begin
                                st_d.wire3 = rx_next[MODE_BIT];
                            end
                        end
                        st_d.ptr = ptr_next;
                    end
                end
            end

            if (sclk_fall && st_q.phase == PH_DATA && st_q.rw) begin
                st_d.dout = st_q.tx[RP_DATA_W-1];
                st_d.tx   = {st_q.tx[RP_DATA_W-2:0], 1'b0};
            end

            st_d.dout_en = st_d.wire3 ? (st_d.phase == PH_DATA && st_d.rw) : 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_addr  = st_q.acc;
    assign reg_wdata = st_q.wdata;
    assign reg_we    = st_q.we;
    assign reg_re    = st_q.re;
    assign dout      = st_q.dout;
    assign dout_en   = st_q.dout_en;
    assign wire3     = st_q.wire3;

endmodule

// File: rtl/spi_regport.sv
module spi_regport
    import spi_regport_pkg::*;
#(
    parameter int unsigned          SYNC_STAGES = 2,
    parameter logic [RP_ADDR_W-1:0] MODE_ADDR   = 6'h31,
    parameter int unsigned          MODE_BIT    = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 spi_cs_n,
    input  logic                 spi_sclk,
    input  logic                 spi_din,
    output logic                 spi_dout,
    output logic                 spi_dout_en,
    output logic [RP_ADDR_W-1:0] reg_addr,
    output logic [RP_DATA_W-1:0] reg_wdata,
    output logic                 reg_we,
    output logic                 reg_re,
    input  logic [RP_DATA_W-1:0] reg_rdata
);

    localparam int unsigned SYNC_W = 3;

    logic [SYNC_W-1:0] pins_s;
    logic              cs_n_s, sclk_s, din_s;
    logic              sclk_rise, sclk_fall;
    logic              wire3_mode;

    spi_regport_sync #(
        .WIDTH   (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b110)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({spi_cs_n, spi_sclk, spi_din}),
        .sync_o  (pins_s)
    );

    assign {cs_n_s, sclk_s, din_s} = pins_s;

    spi_regport_edge #(
        .IDLE_VAL (1'b1)
    ) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (sclk_s),
        .rise_o  (sclk_rise),
        .fall_o  (sclk_fall)
    );

    spi_regport_core #(
        .MODE_ADDR (MODE_ADDR),
        .MODE_BIT  (MODE_BIT)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (~cs_n_s),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .din       (din_s),
        .reg_rdata (reg_rdata),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .dout      (spi_dout),
        .dout_en   (spi_dout_en),
        .wire3     (wire3_mode)
    );

endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic dout_en,
    input logic reg_we,
    input logic reg_re,
    input logic wire3
);

    // R2 / R3: a write and a read are never strobed together
    p_we_re_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re));

    // R2: the write strobe lasts one cycle per byte
    p_we_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R3: the read strobe lasts one cycle per byte
    p_re_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> !reg_re);

    // R10: chip select high for four cycles turns the driver off
    p_oe_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n, 1) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !dout_en);

    // R9: in 3-wire mode the driver only turns on as a read begins
    p_3w_oe_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wire3 && $rose(dout_en)) |-> reg_re);

endmodule

bind spi_regport spi_regport_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (spi_cs_n),
    .dout_en (spi_dout_en),
    .reg_we  (reg_we),
    .reg_re  (reg_re),
    .wire3   (wire3_mode)
);

// File: tb/spi_regport_test.sv
`timescale 1ns/1ps
module spi_regport_test;

    localparam int HALF = 6;
    localparam int NV   = 9;
    // {byte count, command, data0, data1}
    localparam logic [25:0] VEC [NV] = '{
        {2'd1, 8'h05, 8'hA5, 8'h00},   // write 0x05
        {2'd1, 8'h85, 8'hFF, 8'h00},   // read 0x05
        {2'd2, 8'h50, 8'h3C, 8'hC3},   // burst write 0x10,0x11
        {2'd2, 8'hD0, 8'hFF, 8'hFF},   // burst read 0x10,0x11
        {2'd2, 8'h20, 8'h11, 8'h22},   // repeat write 0x20
        {2'd2, 8'h91, 8'hFF, 8'hFF},   // repeat read 0x11
        {2'd2, 8'h7F, 8'h77, 8'h88},   // burst write 0x3F,0x00
        {2'd2, 8'hFF, 8'hFF, 8'hFF},   // burst read 0x3F,0x00
        {2'd1, 8'hAA, 8'hFF, 8'h00}    // read 0x2A (initial)
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_sclk = 1'b1;
    logic       spi_din = 1'b0;
    logic       spi_dout, spi_dout_en;
    logic [5:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       reg_we, reg_re;

    logic [7:0] mem [64];
    logic [7:0] exp_mem [64];
    logic [5:0] wl_a [256];
    logic [7:0] wl_d [256];
    int         wn = 0;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    spi_regport uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_cs_n    (spi_cs_n),
        .spi_sclk    (spi_sclk),
        .spi_din     (spi_din),
        .spi_dout    (spi_dout),
        .spi_dout_en (spi_dout_en),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_we      (reg_we),
        .reg_re      (reg_re),
        .reg_rdata   (reg_rdata)
    );

    assign reg_rdata = mem[reg_addr];

    always @(posedge clk) begin
        if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
            wl_a[wn[7:0]] <= reg_addr;
            wl_d[wn[7:0]] <= reg_wdata;
            wn            <= wn + 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx,
                            output bit any_en, output bit all_en);
        any_en = 1'b0;
        all_en = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            spi_sclk = 1'b0;
            spi_din  = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = spi_dout;
            if (spi_dout_en) any_en = 1'b1;
            else             all_en = 1'b0;
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
    endtask

    task automatic xfer(input logic [7:0] cmd, input int n, input logic [7:0] d0, d1,
                        output logic [7:0] r0, r1,
                        output bit c_any, c_all, d_any, d_all);
        logic [7:0] junk;
        bit a, b;
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        spi_byte(cmd, junk, c_any, c_all);
        d_any = 1'b0;
        d_all = 1'b1;
        r0 = '0;
        r1 = '0;
        if (n >= 1) begin
            spi_byte(d0, r0, a, b);
            d_any |= a; d_all &= b;
        end
        if (n >= 2) begin
            spi_byte(d1, r1, a, b);
            d_any |= a; d_all &= b;
        end
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (4 * HALF) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] r0, r1, rb;
        bit ca, cl, da, dl;
        int w0;

        for (int i = 0; i < 64; i++) begin
            mem[i]     = 8'(i * 7 + 3);
            exp_mem[i] = 8'(i * 7 + 3);
        end

        repeat (5) @(negedge clk);
        // R1: reset state
        check("R1 dout_en", spi_dout_en, 0);
        check("R1 reg_we",  reg_we, 0);
        check("R1 reg_re",  reg_re, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 dout_en after release", spi_dout_en, 0);

        // table walk, 4-wire mode
        for (int v = 0; v < NV; v++) begin
            logic [1:0] n2;
            logic [7:0] cmd, b0, b1;
            logic [5:0] a0, ai;
            string tag;
            {n2, cmd, b0, b1} = VEC[v];
            a0 = cmd[5:0];
            w0 = wn;
            xfer(cmd, int'(n2), b0, b1, r0, r1, ca, cl, da, dl);
            for (int i = 0; i < int'(n2); i++) begin
                ai = cmd[6] ? a0 + 6'(i) : a0;
                if (cmd[6] && i > 0 && a0 == 6'h3F) tag = "R6 wrap";
                else if (cmd[6] && i > 0)           tag = "R4 increment";
                else if (!cmd[6] && i > 0)          tag = "R5 repeat";
                else if (cmd[7])                    tag = "R3 read";
                else                                tag = "R2 write";
                if (cmd[7]) begin
                    check(tag, (i == 0) ? r0 : r1, exp_mem[ai]);
                end else begin
                    check({tag, " addr"}, wl_a[w0 + i], ai);
                    check({tag, " data"}, wl_d[w0 + i], (i == 0) ? b0 : b1);
                    exp_mem[ai] = (i == 0) ? b0 : b1;
                end
            end
            if (!cmd[7]) check("R2 write count", wn - w0, int'(n2));
            check("R8 enable held in 4-wire", {31'd0, cl & dl}, 1);
            check("R10 enable off after cs", spi_dout_en, 0);
        end

        // R7: abort inside a data byte
        w0 = wn;
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        spi_byte(8'h05, rb, ca, cl);
        for (int i = 0; i < 4; i++) begin
            spi_sclk = 1'b0; spi_din = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        spi_cs_n = 1'b1;
        repeat (4 * HALF) @(negedge clk);
        check("R7 no write from partial byte", wn - w0, 0);
        xfer(8'h85, 1, 8'hFF, 8'h00, r0, r1, ca, cl, da, dl);
        check("R7 register untouched", r0, exp_mem[5]);

        // R7: abort inside the command byte, then a clean write
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            spi_sclk = 1'b0; spi_din = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        spi_cs_n = 1'b1;
        repeat (4 * HALF) @(negedge clk);
        w0 = wn;
        xfer(8'h06, 1, 8'h5A, 8'h00, r0, r1, ca, cl, da, dl);
        check("R7 fresh command addr", wl_a[w0], 6'h06);
        check("R7 fresh command data", wl_d[w0], 8'h5A);
        exp_mem[6] = 8'h5A;

        // R9: other bits of the mode register leave 4-wire mode
        xfer(8'h31, 1, 8'hBF, 8'h00, r0, r1, ca, cl, da, dl);
        exp_mem[6'h31] = 8'hBF;
        xfer(8'h07, 1, 8'h66, 8'h00, r0, r1, ca, cl, da, dl);
        exp_mem[7] = 8'h66;
        check("R9 bit6 clear keeps 4-wire", {31'd0, cl & dl}, 1);

        // R9: bit 6 set selects 3-wire
        w0 = wn;
        xfer(8'h31, 1, 8'h40, 8'h00, r0, r1, ca, cl, da, dl);
        exp_mem[6'h31] = 8'h40;
        check("R9 mode write addr", wl_a[w0], 6'h31);
        xfer(8'h07, 1, 8'h99, 8'h00, r0, r1, ca, cl, da, dl);
        exp_mem[7] = 8'h99;
        check("R9 3-wire write no drive", {31'd0, ca | da}, 0);
        xfer(8'h87, 1, 8'hFF, 8'h00, r0, r1, ca, cl, da, dl);
        check("R9 3-wire command no drive", {31'd0, ca}, 0);
        check("R9 3-wire read data driven", {31'd0, dl}, 1);
        check("R3 read in 3-wire", r0, 8'h99);
        check("R10 3-wire idle", spi_dout_en, 0);

        // R9: bit 6 clear returns to 4-wire
        xfer(8'h31, 1, 8'h00, 8'h00, r0, r1, ca, cl, da, dl);
        exp_mem[6'h31] = 8'h00;
        xfer(8'h08, 1, 8'h12, 8'h00, r0, r1, ca, cl, da, dl);
        check("R8 back in 4-wire", {31'd0, cl & dl}, 1);
        check("R2 write after mode change", mem[8], 8'h12);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule